// File: doc/BRIEF.md
# Single-Transfer Word Load/Store Datapath

This block carries out one word load or one word store for a processor with a 26-bit byte address space. The issuing stage pulses `start` with the operation fields: the base register value and index, the destination (or store source) register index, a precomputed offset, the indexing mode, the writeback flag, the direction and the register-shift flag. The unit computes the transfer address and the base writeback value. It drives one aligned memory access. For a load, it aligns the returned word to the addressed byte. It then presents up to two register-file writes in a single completion cycle.

The offset arrives in two forms. `offImm` is the offset as an immediate-shift encoding would produce it, and `offShift` is the offset as the register-shift encoding would produce it. Three cases are fixed here rather than left undefined: transfers to unaligned addresses, a destination register equal to the base register, and the register-shift encoding. The register-shift encoding costs one stall cycle. A load in that encoding takes its address from the register-shift offset and its writeback from the immediate offset. A store in that encoding ignores the register-shift offset entirely.

Top module: `ls_single_xfer`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `memRd`, `memWr`, `rfLdEn` and `rfWbEn` are low until a `start` is accepted.
- R2: A `start` accepted while idle gives an access cycle in the next cycle. Without the register-shift flag, `done` and the register writes follow in the cycle after the access. A `start` raised while `busy` is high is ignored.
- R3: With the register-shift flag set, loads and stores both have exactly one extra cycle between the access cycle and the completion cycle. During that extra cycle `busy` is high and no strobe is driven.
- R4: In pre-indexed mode the transfer address is base plus offset. In post-indexed mode it is the base alone. The writeback value is base plus `offImm` in both modes. All sums are taken modulo 2^26.
- R5: `memAddr` always has its two low bits at zero. It selects the word that contains the computed transfer address.
- R6: A load result equals the fetched word rotated right by 8 times the two low bits of the transfer address, so that the addressed byte lands in bits 7:0.
- R7: A store writes `storeVal` unrotated to the aligned word. With writeback enabled, the base receives the full unaligned value.
- R8: When a load's destination index equals its base index, the loaded value is written and the base writeback is suppressed, in both index modes.
- R9: When a store's source index equals its base index, the stored data is the register value supplied at `start`, and the base writeback still takes place.
- R10: A register-shift load uses `offShift` for its address and `offImm` for its writeback value.
- R11: A register-shift store ignores `offShift`. Both its address and its writeback come from `offImm`.
- R12: `rfWbEn` is high only in the completion cycle of an operation with writeback enabled. `rfLdEn` is high only in the completion cycle of a load.
- R13: `memRd` and `memWr` are never high together. Each is high only in the access cycle, `memRd` for loads and `memWr` for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue pulse; accepted only while idle |
| isLoad | input | 1 | 1 = load, 0 = store |
| preIndex | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| writeBack | input | 1 | Request base register update |
| regShift | input | 1 | Instruction uses the register-shift offset encoding |
| baseVal | input | 26 | Base register value |
| offImm | input | 26 | Offset under immediate-shift interpretation |
| offShift | input | 26 | Offset under register-shift interpretation |
| storeVal | input | 32 | Store source register value |
| rdIdx | input | 4 | Destination / store source register index |
| rnIdx | input | 4 | Base register index |
| rdData | input | 32 | Memory read data, valid in the access cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion cycle |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | 26 | Word-aligned memory address |
| memWdata | output | 32 | Store data |
| rfLdEn | output | 1 | Loaded-value register write enable |
| rfLdIdx | output | 4 | Loaded-value register index |
| rfLdData | output | 32 | Rotated load result |
| rfWbEn | output | 1 | Base writeback enable |
| rfWbIdx | output | 4 | Base writeback register index |
| rfWbData | output | 26 | Base writeback value |

## Verification
The bench sweeps every combination of direction, index mode, writeback, register-shift flag, all four low address bits and same/different register indices, with bases that straddle the top of the 26-bit space. Each case has its own failure signature. A design that skips the alignment would present odd addresses or write the wrong word. A design that rotates the wrong way, or not at all, would return misplaced bytes. A design that lets the writeback win on a load with equal registers would corrupt the loaded value. A design that mixes up the two offsets in the register-shift form would address or write back the wrong location, and one that drops the stall would finish a cycle early.

// File: rtl/ls_xfer_pkg.sv
package ls_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_STALL  = 2'd2,
    ST_FINISH = 2'd3
  } xferState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch operation fields
    logic access;   // memory access cycle
    logic finish;   // register-file write cycle
  } xferStrobe_t;

endpackage

// File: rtl/ls_xfer_ctrl.sv
module ls_xfer_ctrl
  import ls_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        regShift,
  output xferStrobe_t strobe,
  output logic        busy
);

  xferState_t state, stateNext;
  logic       shiftQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_ACCESS;
      ST_ACCESS: stateNext = shiftQ ? ST_STALL : ST_FINISH;
      ST_STALL:  stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      shiftQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) shiftQ <= regShift;
    end
  end

  always_comb begin
    strobe.capture = (state == ST_IDLE) && start;
    strobe.access  = (state == ST_ACCESS);
    strobe.finish  = (state == ST_FINISH);
  end

  assign busy = (state != ST_IDLE);

  AST_STALL_THEN_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STALL) |=> (state == ST_FINISH)); // R3
  AST_FINISH_FOLLOWS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> ($past(strobe.access) || $past(state == ST_STALL))); // R2
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.access, strobe.finish, state == ST_STALL})); // R2

endmodule

// File: rtl/ls_xfer_datapath.sv
module ls_xfer_datapath
  import ls_xfer_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              isLoad,
  input  logic              preIndex,
  input  logic              writeBack,
  input  logic              regShift,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offImm,
  input  logic [ADDR_W-1:0] offShift,
  input  logic [DATA_W-1:0] storeVal,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  rnIdx,
  input  logic [DATA_W-1:0] rdData,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rfLdEn,
  output logic [IDX_W-1:0]  rfLdIdx,
  output logic [DATA_W-1:0] rfLdData,
  output logic              rfWbEn,
  output logic [IDX_W-1:0]  rfWbIdx,
  output logic [ADDR_W-1:0] rfWbData
);

  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic              loadQ, preQ, wbQ, shiftQ;
  logic [ADDR_W-1:0] baseQ, offImmQ, offShiftQ;
  logic [DATA_W-1:0] storeQ, loadWordQ;
  logic [IDX_W-1:0]  rdQ, rnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadQ     <= 1'b0;
      preQ      <= 1'b0;
      wbQ       <= 1'b0;
      shiftQ    <= 1'b0;
      baseQ     <= '0;
      offImmQ   <= '0;
      offShiftQ <= '0;
      storeQ    <= '0;
      rdQ       <= '0;
      rnQ       <= '0;
    end else if (strobe.capture) begin
      loadQ     <= isLoad;
      preQ      <= preIndex;
      wbQ       <= writeBack;
      shiftQ    <= regShift;
      baseQ     <= baseVal;
      offImmQ   <= offImm;
      offShiftQ <= offShift;
      storeQ    <= storeVal;
      rdQ       <= rdIdx;
      rnQ       <= rnIdx;
    end
  end

  // Address generation: only a register-shift load uses the shift offset
  logic [ADDR_W-1:0] addrOff, addrSum, xferAddr, wbSum;
  always_comb begin
    addrOff  = (loadQ && shiftQ) ? offShiftQ : offImmQ;
    addrSum  = baseQ + addrOff;
    xferAddr = preQ ? addrSum : baseQ;
    wbSum    = baseQ + offImmQ;
  end

  // Byte rotation of the fetched word
  logic [LANE_BITS-1:0] rotSel;
  logic [DATA_W-1:0]    rotWord;
  assign rotSel = xferAddr[LANE_BITS-1:0];

  always_comb begin
    rotWord = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [LANE_BITS-1:0] src;
      src = LANE_BITS'(i) + rotSel;
      rotWord[i*8 +: 8] = rdData[src*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) loadWordQ <= '0;
    else if (strobe.access && loadQ) loadWordQ <= rotWord;
  end

  assign memRd    = strobe.access && loadQ;
  assign memWr    = strobe.access && !loadQ;
  assign memAddr  = {xferAddr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
  assign memWdata = storeQ;

  assign rfLdEn   = strobe.finish && loadQ;
  assign rfLdIdx  = rdQ;
  assign rfLdData = loadWordQ;
  assign rfWbEn   = strobe.finish && wbQ && !(loadQ && rdQ == rnQ);
  assign rfWbIdx  = rnQ;
  assign rfWbData = wbSum;

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (memAddr[LANE_BITS-1:0] == '0)); // R5
  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R13
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (rfLdEn && rfWbEn) |-> (rfLdIdx != rfWbIdx)); // R8
  AST_LOAD_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rfLdEn && !$past(memRd)) |-> $stable(rfLdData)); // R3
  AST_WB_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (rfWbEn || rfLdEn) |-> !(memRd || memWr)); // R12

endmodule

// File: rtl/ls_single_xfer.sv
module ls_single_xfer
  import ls_xfer_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isLoad,
  input  logic              preIndex,
  input  logic              writeBack,
  input  logic              regShift,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offImm,
  input  logic [ADDR_W-1:0] offShift,
  input  logic [DATA_W-1:0] storeVal,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  rnIdx,
  input  logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rfLdEn,
  output logic [IDX_W-1:0]  rfLdIdx,
  output logic [DATA_W-1:0] rfLdData,
  output logic              rfWbEn,
  output logic [IDX_W-1:0]  rfWbIdx,
  output logic [ADDR_W-1:0] rfWbData
);

  xferStrobe_t strobe;

  ls_xfer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .regShift (regShift),
    .strobe   (strobe),
    .busy     (busy)
  );

  ls_xfer_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .isLoad    (isLoad),
    .preIndex  (preIndex),
    .writeBack (writeBack),
    .regShift  (regShift),
    .baseVal   (baseVal),
    .offImm    (offImm),
    .offShift  (offShift),
    .storeVal  (storeVal),
    .rdIdx     (rdIdx),
    .rnIdx     (rnIdx),
    .rdData    (rdData),
    .memRd     (memRd),
    .memWr     (memWr),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rfLdEn    (rfLdEn),
    .rfLdIdx   (rfLdIdx),
    .rfLdData  (rfLdData),
    .rfWbEn    (rfWbEn),
    .rfWbIdx   (rfWbIdx),
    .rfWbData  (rfWbData)
  );

  assign done = strobe.finish;

endmodule

// File: tb/sim_ls_single_xfer.sv
module sim_ls_single_xfer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isLoad = 1'b0, preIndex = 1'b0, writeBack = 1'b0, regShift = 1'b0;
  logic [25:0] baseVal = '0, offImm = '0, offShift = '0;
  logic [31:0] storeVal = '0, rdData;
  logic [3:0]  rdIdx = '0, rnIdx = '0;
  logic        busy, done, memRd, memWr, rfLdEn, rfWbEn;
  logic [25:0] memAddr, rfWbData;
  logic [31:0] memWdata, rfLdData;
  logic [3:0]  rfLdIdx, rfWbIdx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memFn(input logic [25:0] a);
    return 32'h9E37_79B9 ^ ({6'd0, a} * 32'h0004_0003);
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] w, input logic [1:0] s);
    logic [63:0] d;
    d = {w, w} >> (8 * s);
    return d[31:0];
  endfunction

  assign rdData = memFn(memAddr);

  ls_single_xfer u0 (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad), .preIndex(preIndex),
    .writeBack(writeBack), .regShift(regShift), .baseVal(baseVal), .offImm(offImm),
    .offShift(offShift), .storeVal(storeVal), .rdIdx(rdIdx), .rnIdx(rnIdx),
    .rdData(rdData), .busy(busy), .done(done), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWdata(memWdata), .rfLdEn(rfLdEn), .rfLdIdx(rfLdIdx),
    .rfLdData(rfLdData), .rfWbEn(rfWbEn), .rfWbIdx(rfWbIdx), .rfWbData(rfWbData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOp(input bit ld, input bit pre, input bit wb, input bit rs,
                       input logic [25:0] base, input logic [1:0] lowBits, input bit same);
    logic [25:0] oImm, oSh, useOff, xAddr, wbVal;
    logic [31:0] sv, expLoad;
    logic [3:0]  rd, rn;
    oImm = 26'h0000104 + 26'(lowBits);
    oSh  = 26'h0002230 + 26'({lowBits, 1'b0});
    sv   = 32'hC0DE_0000 ^ {6'd0, base};
    rn   = 4'd7;
    rd   = same ? 4'd7 : 4'd3;
    useOff  = (ld && rs) ? oSh : oImm;                    // R10 R11
    xAddr   = pre ? (base + useOff) : base;               // R4
    wbVal   = base + oImm;                                // R4 R7
    expLoad = rotr(memFn({xAddr[25:2], 2'b00}), xAddr[1:0]); // R6

    // Issue at a negedge
    isLoad = ld; preIndex = pre; writeBack = wb; regShift = rs;
    baseVal = base; offImm = oImm; offShift = oSh; storeVal = sv;
    rdIdx = rd; rnIdx = rn; start = 1'b1;
    @(negedge clk);
    // Access cycle; disturb inputs and hold start to test ignore (R2)
    baseVal = ~base; offImm = 26'h155; offShift = 26'h2AA; storeVal = ~sv;
    rdIdx = 4'd1; rnIdx = 4'd2; isLoad = ~ld;
    chk(busy && !done, "R2 access busy", {30'd0, busy, done}, 32'h2);
    chk(memRd == ld && memWr == !ld, "R13 strobes", {30'd0, memRd, memWr}, {30'd0, ld, !ld});
    chk(memAddr == {xAddr[25:2], 2'b00}, "R5 address", {6'd0, memAddr}, {6'd0, xAddr[25:2], 2'b00});
    if (!ld) chk(memWdata == sv, same ? "R9 store old value" : "R7 store data", memWdata, sv);
    if (rs) begin
      @(negedge clk);
      chk(busy && !done && !memRd && !memWr && !rfLdEn && !rfWbEn, "R3 stall cycle",
          {26'd0, busy, done, memRd, memWr, rfLdEn, rfWbEn}, 32'h20);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done && !memRd && !memWr, "R2 completion", {29'd0, done, memRd, memWr}, 32'h4);
    chk(rfLdEn == ld, "R12 load enable", {31'd0, rfLdEn}, {31'd0, ld});
    if (ld) begin
      chk(rfLdData == expLoad, rs ? "R10 R6 load data" : "R6 load data", rfLdData, expLoad);
      chk(rfLdIdx == rd, "R8 load index", {28'd0, rfLdIdx}, {28'd0, rd});
    end
    if (ld && same)
      chk(!rfWbEn, "R8 writeback suppressed", {31'd0, rfWbEn}, 32'd0);
    else
      chk(rfWbEn == wb, "R12 writeback enable", {31'd0, rfWbEn}, {31'd0, wb});
    if (wb && !(ld && same)) begin
      chk(rfWbData == wbVal, rs ? (ld ? "R10 writeback" : "R11 writeback") : "R4 R7 writeback",
          {6'd0, rfWbData}, {6'd0, wbVal});
      chk(rfWbIdx == rn, "R9 writeback index", {28'd0, rfWbIdx}, {28'd0, rn});
    end
    @(negedge clk);
    chk(!busy && !done, "R2 back to idle", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    logic [25:0] bases [3];
    bases[0] = 26'h0000000;
    bases[1] = 26'h3FFFEF0;
    bases[2] = 26'h1234560;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memRd && !memWr && !rfLdEn && !rfWbEn, "R1 in reset",
        {26'd0, busy, done, memRd, memWr, rfLdEn, rfWbEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memRd && !memWr && !rfLdEn && !rfWbEn, "R1 after reset",
        {26'd0, busy, done, memRd, memWr, rfLdEn, rfWbEn}, 32'd0);
    for (int b = 0; b < 3; b++)
      for (int m = 0; m < 64; m++)
        runOp(m[0], m[1], m[2], m[3], bases[b] + 26'(m[5:4] * 4), m[5:4], 1'b0);
    for (int b = 0; b < 3; b++)
      for (int m = 0; m < 64; m++)
        runOp(m[0], m[1], m[2], m[3], bases[b] + 26'(m[5:4]), m[5:4], 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule